// File: doc/BRIEF.md
# Watchdog and Power-On Reset Supervisor

This block generates the reset line for a host processor. After power-up it holds reset for a fixed settling period, and it does the same while a supply-low indication is present and for that period after the indication clears. Once reset is released, a watchdog counter runs on a prescaled timebase. The host restarts the counter by producing a falling edge on a pin that it shares with its serial chip-select. If the host does not restart the counter in time, the block pulls reset for another settling period.

The watchdog interval is one of three preset lengths, or the watchdog is switched off. A two-bit configuration code selects the setting. That code comes from non-volatile storage and is captured once after power-up, so later changes on the configuration input have no effect until the next power cycle. The settling period and the three intervals are parameters counted in timebase ticks.

Top module: `rsv_supervisor`

## Requirements
- R1: While `rst_n` is low, `rst_out` is high. After `rst_n` rises, `rst_out` stays high until HOLD_TICKS timebase ticks have occurred, then falls.
- R2: The settling and watchdog counters advance only on clock cycles with `tick` high. Without ticks, neither reset release nor a watchdog timeout occurs.
- R3: With code 2'b00, 2'b01 or 2'b10 on `cfg_nv` at power-up, `rst_out` rises after LONG_TICKS, MED_TICKS or SHORT_TICKS ticks respectively without a restart. The count starts from reset release or from the last restart.
- R4: Code 2'b11 disables the watchdog. `rst_out` then stays low however long the host is silent.
- R5: `cfg_nv` is captured in the first cycle after `rst_n` rises. Later changes on it do not alter the interval in use.
- R6: A falling edge on `wdi` restarts the watchdog counter. It passes through a two-flop synchroniser, so the counter restarts on the third clock edge after the pin falls. A steady level or a rising edge does not restart the counter.
- R7: While `supply_low` is high, `rst_out` is high from the next clock edge and the settling counter is held at zero. After `supply_low` falls, a full HOLD_TICKS period elapses before release.
- R8: A reset caused by a watchdog timeout lasts HOLD_TICKS ticks.
- R9: The watchdog counter is held at zero while reset is active, so each release starts a full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | Prescaled timebase enable, one cycle per tick |
| supply_low | input | 1 | Supply-fail indication, active high |
| wdi | input | 1 | Shared chip-select / watchdog restart pin, asynchronous |
| cfg_nv | input | 2 | Non-volatile watchdog interval code |
| rst_out | output | 1 | Reset to host, active high |

## Verification
The hardest case to reach is a restart edge that arrives just before expiry. A pin transition shows up at the counter only three clock edges later. The bench therefore drives one-cycle low pulses on `wdi` at a fixed cadence and then stops. It expects the timeout exactly SHORT_TICKS plus three edges after the last falling edge. It also holds `wdi` low through power-up and raises it mid-interval, which shows that a level and a rising edge leave the exact timeout edge unchanged. The bench gates `tick` off at the moment reset releases, so the counter is frozen at zero. This gives an exact reference point for the restarted interval.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // Watchdog interval code, as captured from non-volatile configuration
    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MED   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

endpackage

// File: rtl/rsv_edge_sync.sv
module rsv_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = pin;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    // Pin idles high (chip-select deasserted)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '{s1: 1'b1, s2: 1'b1, s3: 1'b1};
        else        sync_q <= sync_d;
    end

    assign fall = sync_q.s3 & ~sync_q.s2;

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R6

endmodule

// File: rtl/rsv_hold_timer.sv
module rsv_hold_timer #(
    parameter int HOLD_TICKS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic done
);

    localparam int CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;

    assign done = !clear && tick && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (clear)     st_d.cnt = '0;
        else if (done) st_d.cnt = '0;
        else if (tick) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

    AST_HOLD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST); // R1

    AST_HOLD_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !clear |=> $stable(st_q.cnt)); // R2

endmodule

// File: rtl/rsv_wd_timer.sv
module rsv_wd_timer
    import rsv_pkg::*;
#(
    parameter int LONG_TICKS  = 48,
    parameter int MED_TICKS   = 24,
    parameter int SHORT_TICKS = 10
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear,
    input  logic    kick,
    input  logic    tick,
    input  wd_sel_e sel,
    output logic    expire
);

    localparam int MAXT = (LONG_TICKS > MED_TICKS)
                        ? ((LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS)
                        : ((MED_TICKS > SHORT_TICKS) ? MED_TICKS : SHORT_TICKS);
    localparam int CW = $clog2(MAXT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } wd_st_t;

    wd_st_t        st_d, st_q;
    logic [CW-1:0] limit;
    logic          enabled;

    always_comb begin
        enabled = 1'b1;
        case (sel)
            WD_LONG:  limit = CW'(LONG_TICKS);
            WD_MED:   limit = CW'(MED_TICKS);
            WD_SHORT: limit = CW'(SHORT_TICKS);
            default: begin
                limit   = CW'(LONG_TICKS);
                enabled = 1'b0;
            end
        endcase
    end

    assign expire = !clear && !kick && tick && enabled
                  && (st_q.cnt == limit - 1'b1);

    always_comb begin
        st_d = st_q;
        if (clear || kick)        st_d.cnt = '0;
        else if (expire)          st_d.cnt = '0;
        else if (tick && enabled) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

    AST_WD_CLEAR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.cnt == '0); // R9

    AST_WD_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> st_q.cnt == '0); // R6

    AST_WD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |-> st_q.cnt < limit); // R3

endmodule

// File: rtl/rsv_supervisor.sv
module rsv_supervisor
    import rsv_pkg::*;
#(
    parameter int HOLD_TICKS  = 12,
    parameter int LONG_TICKS  = 48,
    parameter int MED_TICKS   = 24,
    parameter int SHORT_TICKS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       supply_low,
    input  logic       wdi,
    input  logic [1:0] cfg_nv,
    output logic       rst_out
);

    typedef struct packed {
        logic    hold;    // reset to host active
        logic    loaded;  // configuration captured since power-up
        wd_sel_e cfg;
    } sup_st_t;

    sup_st_t st_d, st_q;
    logic    wdi_fall;
    logic    hold_done;
    logic    wd_expire;

    rsv_edge_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (wdi),
        .fall  (wdi_fall)
    );

    rsv_hold_timer #(
        .HOLD_TICKS (HOLD_TICKS)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (supply_low || !st_q.hold),
        .tick  (tick),
        .done  (hold_done)
    );

    rsv_wd_timer #(
        .LONG_TICKS  (LONG_TICKS),
        .MED_TICKS   (MED_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (st_q.hold),
        .kick   (wdi_fall),
        .tick   (tick),
        .sel    (st_q.cfg),
        .expire (wd_expire)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.loaded) begin
            st_d.loaded = 1'b1;
            st_d.cfg    = wd_sel_e'(cfg_nv);
        end
        if (supply_low)                  st_d.hold = 1'b1;
        else if (st_q.hold && hold_done) st_d.hold = 1'b0;
        else if (!st_q.hold && wd_expire) st_d.hold = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{hold: 1'b1, loaded: 1'b0, cfg: WD_OFF};
        else        st_q <= st_d;
    end

    assign rst_out = st_q.hold;

    AST_SUPPLY_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> rst_out); // R7

    AST_NO_RELEASE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> !$past(supply_low)); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.loaded && $past(st_q.loaded) |-> $stable(st_q.cfg)); // R5

    AST_OFF_NEVER_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.loaded && st_q.cfg == WD_OFF && !st_q.hold && !supply_low
        |=> !st_q.hold); // R4

endmodule

// File: tb/rsv_supervisor_tb.sv
`timescale 1ns/1ps
module rsv_supervisor_tb;

    localparam int H  = 12;
    localparam int LG = 48;
    localparam int MD = 24;
    localparam int SH = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       supply_low = 1'b0;
    logic       wdi = 1'b1;
    logic [1:0] cfg_nv = 2'b00;
    logic       rst_out;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    rsv_supervisor #(
        .HOLD_TICKS  (H),
        .LONG_TICKS  (LG),
        .MED_TICKS   (MD),
        .SHORT_TICKS (SH)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .supply_low (supply_low),
        .wdi        (wdi),
        .cfg_nv     (cfg_nv),
        .rst_out    (rst_out)
    );

    task automatic chk(input string tag, input logic exp);
        n_chk++;
        if (rst_out !== exp) begin
            n_err++;
            $display("FAIL %s: rst_out=%0b expected %0b", tag, rst_out, exp);
        end
    endtask

    // From a falling edge, let n rising edges pass, then stop at the next falling edge
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic power_on(input logic [1:0] cfg, input logic tk, input logic w);
        @(negedge clk);
        rst_n = 1'b0; cfg_nv = cfg; tick = tk; wdi = w; supply_low = 1'b0;
        edges(2);
        chk("R1 reset held during rst_n", 1'b1);
        rst_n = 1'b1;
    endtask

    task automatic expect_hold(input string tag);
        edges(H - 1);
        chk({tag, " still held"}, 1'b1);
        edges(1);
        chk({tag, " released"}, 1'b0);
    endtask

    task automatic expect_timeout(input int lim, input string tag);
        edges(lim - 1);
        chk({tag, " no trip before interval"}, 1'b0);
        edges(1);
        chk({tag, " trip at interval"}, 1'b1);
        expect_hold("R8 timeout hold");
        edges(lim - 1);
        chk("R9 full interval after timeout", 1'b0);
        edges(1);
        chk("R9 trips again", 1'b1);
    endtask

    task automatic t_intervals();
        power_on(2'b00, 1'b1, 1'b1);
        expect_hold("R1 power-on");
        expect_timeout(LG, "R3 long");
        power_on(2'b01, 1'b1, 1'b1);
        expect_hold("R1 power-on");
        expect_timeout(MD, "R3 medium");
    endtask

    task automatic t_cfg_frozen();
        power_on(2'b10, 1'b1, 1'b1);
        edges(2);
        cfg_nv = 2'b00;
        edges(H - 3);
        chk("R5 held", 1'b1);
        edges(1);
        chk("R5 released", 1'b0);
        expect_timeout(SH, "R5 short kept after cfg change");
    endtask

    task automatic t_disabled();
        power_on(2'b11, 1'b1, 1'b1);
        expect_hold("R1 power-on");
        edges(LG + 5);
        chk("R4 disabled mid", 1'b0);
        edges(2 * LG);
        chk("R4 disabled end", 1'b0);
    endtask

    task automatic t_kick();
        power_on(2'b10, 1'b1, 1'b1);
        expect_hold("R1 power-on");
        for (int i = 0; i < 8; i++) begin
            wdi = 1'b0;
            edges(1);
            wdi = 1'b1;
            edges(4);
            chk("R6 kicked, no trip", 1'b0);
        end
        wdi = 1'b0;
        edges(1);
        wdi = 1'b1;
        edges(SH + 1);
        chk("R6 last kick, before trip", 1'b0);
        edges(1);
        chk("R6 trip SH+3 edges after fall", 1'b1);
    endtask

    task automatic t_level();
        power_on(2'b10, 1'b1, 1'b0);
        expect_hold("R1 power-on wdi low");
        edges(SH / 2);
        wdi = 1'b1;
        edges(SH - 1 - SH / 2);
        chk("R6 rising edge no restart, before trip", 1'b0);
        edges(1);
        chk("R6 rising edge no restart, trip", 1'b1);
    endtask

    task automatic t_supply();
        power_on(2'b01, 1'b1, 1'b1);
        expect_hold("R1 power-on");
        edges(5);
        supply_low = 1'b1;
        edges(1);
        chk("R7 supply low forces reset", 1'b1);
        edges(40);
        chk("R7 held while low", 1'b1);
        supply_low = 1'b0;
        expect_hold("R7 after recovery");
        power_on(2'b01, 1'b1, 1'b1);
        edges(H / 2);
        supply_low = 1'b1;
        edges(2);
        supply_low = 1'b0;
        expect_hold("R7 mid-hold restart");
    endtask

    task automatic t_tick();
        power_on(2'b10, 1'b0, 1'b1);
        edges(3 * H);
        chk("R2 no ticks, hold stays", 1'b1);
        tick = 1'b1;
        edges(H - 1);
        chk("R2 ticks resume, held", 1'b1);
        tick = 1'b0;
        edges(1);
        chk("R2 release on last tick", 1'b1);
        tick = 1'b1;
        edges(1);
        chk("R2 released", 1'b0);
        tick = 1'b0;
        edges(5 * SH);
        chk("R2 no ticks, no timeout", 1'b0);
        tick = 1'b1;
        expect_timeout(SH, "R2 interval after gating");
    endtask

    initial begin
        #(5ns * 150000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: run hung, rst_out=%0b expected progress", rst_out);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_intervals();
        t_cfg_frozen();
        t_disabled();
        t_kick();
        t_level();
        t_supply();
        t_tick();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule